// File: doc/BRIEF.md
# Dual Timer/Counter with Four Counting Modes

This block provides two independent 16-bit timer/counter channels behind a byte-wide register port. A channel advances either once per machine cycle or once per falling edge on its own external input. A machine cycle is twelve system clocks. Falling edges pass a synchronizer and a detector that samples once per machine cycle. An optional gate makes a channel count only while its run bit is set and its external input is high.

Each channel selects one of four counting modes: a 13-bit mode with a 5-bit prescale field in the low byte, a plain 16-bit mode, and an 8-bit mode whose low byte reloads from the high byte when it wraps. In the fourth mode channel 1 freezes. Channel 0 splits into two 8-bit counters, and its high byte is then run by channel 1's run bit and drives overflow flag 1. The overflow flags stay set until software clears them and are also driven out as plain pins.

Register map (byte addresses on `addr_i`): 0 mode, 1 control, 2 channel 0 low byte, 3 channel 0 high byte, 4 channel 1 low byte, 5 channel 1 high byte. Addresses 6 and 7 read as zero.

Top module: `twin_timer_counter`

## Requirements
- R1: With the external-select bit clear, a running channel advances by exactly one per machine cycle of 12 clocks, so a run window of 12·N clocks adds exactly N.
- R2: With the external-select bit set, a running channel advances once for each falling edge of its external input, provided each level is held for at least one machine cycle. A rising edge does not advance it.
- R3: After reset all six registers read 0x00 and `ovf_o` is 0. The mode register reads back what was written. Bits [3:0] configure channel 0 and bits [7:4] configure channel 1, each nibble being {gate, external-select, mode[1:0]} from MSB to LSB.
- R4: With gate set, a channel advances only while its run bit is 1 and its external input is high. With gate clear, the run bit alone enables it.
- R5: Mode 00 (13-bit): bits [4:0] of the low byte count and carry into the high byte, and bits [7:5] of the low byte hold. Flag sets when the high byte wraps from 0xFF to 0x00.
- R6: Mode 01 (16-bit): {high, low} counts as one 16-bit value. The flag sets on the wrap from 0xFFFF to 0x0000.
- R7: Mode 10 (8-bit reload): the low byte counts. When it would pass 0xFF, it loads the high byte value instead and the flag sets. The high byte is unchanged.
- R8: Mode 11 on channel 1 holds both of its count bytes whatever its run bit or input does.
- R9: Mode 11 on channel 0 splits it. The low byte uses channel 0's gate, select and run bit and sets flag 0. The high byte counts machine cycles while channel 1's run bit is set and sets flag 1 when it wraps from 0xFF. In this mode channel 1 does not set flag 1.
- R10: A register write to a count byte wins over an increment of that byte in the same cycle.
- R11: Control register (address 1): bit 0 runs channel 0, bit 1 runs channel 1, bit 4 is flag 0, bit 5 is flag 1. A flag stays set until a control write with a 1 in its bit position. Writing 0 there leaves it untouched. `ovf_o[k]` equals flag k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for reads and writes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| ext_i | input | 2 | External event/gate input per channel |
| ovf_o | output | 2 | Sticky overflow flags, channel order |

## Verification
The assertions assume that the external inputs are asynchronous levels that settle within the synchronizer, and that register writes come as single-cycle strobes. They also assume that nothing but the count logic and writes moves a count byte. The stimulus holds every external level for several machine cycles, so no edge falls below the detector's resolution. Gate levels are set and allowed to settle before a run window opens. Run windows are opened and closed by control writes spaced an exact multiple of twelve clocks apart, so expected counts do not depend on the prescaler phase.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int BYTE_W   = 8;
  localparam int MC_DIV   = 12;
  localparam int PRE_W    = 5;
  localparam int NCH      = 2;
  localparam int ADDR_W   = 3;
  localparam int NIB_W    = 4;
  localparam int RUN_LSB  = 0;
  localparam int FLAG_LSB = 4;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_LO0  = 3'd2;

  typedef enum logic [1:0] {
    M_PRE13   = 2'b00,
    M_FULL16  = 2'b01,
    M_RELOAD8 = 2'b10,
    M_SPECIAL = 2'b11
  } cmode_e;

  typedef struct packed {
    logic   gate;
    logic   ext_sel;
    cmode_e mode;
  } chcfg_t;
endpackage

// File: rtl/tc_cycle_div.sv
module tc_cycle_div #(
  parameter int DIV = dtc_pkg::MC_DIV
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = $clog2(DIV);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

  // R1
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tc_edge_sense.sv
module tc_edge_sense (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ext_i,
  output logic lvl_o,
  output logic fall_o
);
  logic [1:0] sync_q;
  logic       smp_q;
  logic       fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      smp_q  <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], ext_i};
      // one sample per machine cycle; a fall needs high then low on two samples
      if (tick_i) smp_q <= sync_q[1];
      fall_q <= tick_i & smp_q & ~sync_q[1];
    end
  end

  assign lvl_o  = sync_q[1];
  assign fall_o = fall_q;

  // R2
  fall_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> $past(tick_i));
  // R2
  fall_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/tc_channel.sv
module tc_channel
  import dtc_pkg::*;
#(
  parameter int  BW       = BYTE_W,
  parameter int  PW       = PRE_W,
  parameter bit  SPLIT_EN = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          fall_i,
  input  logic          lvl_i,
  input  logic          run_i,
  input  logic          aux_run_i,
  input  logic          gate_i,
  input  logic          ext_sel_i,
  input  cmode_e        mode_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [BW-1:0] wdata_i,
  output logic [BW-1:0] lo_o,
  output logic [BW-1:0] hi_o,
  output logic          ovf_o,
  output logic          ovf_aux_o
);
  localparam logic [BW-1:0]   ONE  = BW'(1);
  localparam logic [BW-1:0]   ALL1 = '1;
  localparam logic [2*BW-1:0] ONE2 = (2*BW)'(1);

  logic [BW-1:0] lo_q, hi_q, lo_n, hi_n;
  logic          run_ok, step, inc;
  logic [PW:0]   pre_sum;

  assign run_ok  = run_i & (~gate_i | lvl_i);
  assign step    = ext_sel_i ? fall_i : tick_i;
  assign inc     = run_ok & step;
  assign pre_sum = {1'b0, lo_q[PW-1:0]} + (PW+1)'(1);

  always_comb begin
    lo_n      = lo_q;
    hi_n      = hi_q;
    ovf_o     = 1'b0;
    ovf_aux_o = 1'b0;
    unique case (mode_i)
      M_PRE13: if (inc) begin
        lo_n[PW-1:0] = pre_sum[PW-1:0];
        if (pre_sum[PW]) begin
          hi_n  = hi_q + ONE;
          ovf_o = (hi_q == ALL1);
        end
      end
      M_FULL16: if (inc) begin
        {hi_n, lo_n} = {hi_q, lo_q} + ONE2;
        ovf_o        = (hi_q == ALL1) && (lo_q == ALL1);
      end
      M_RELOAD8: if (inc) begin
        if (lo_q == ALL1) begin
          lo_n  = hi_q;
          ovf_o = 1'b1;
        end else begin
          lo_n = lo_q + ONE;
        end
      end
      M_SPECIAL: if (SPLIT_EN) begin
        if (inc) begin
          lo_n  = lo_q + ONE;
          ovf_o = (lo_q == ALL1);
        end
        if (tick_i && aux_run_i) begin
          hi_n      = hi_q + ONE;
          ovf_aux_o = (hi_q == ALL1);
        end
      end
      default: ;
    endcase
    // software write beats the increment
    if (wr_lo_i) lo_n = wdata_i;
    if (wr_hi_i) hi_n = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  // R1
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !fall_i && !wr_lo_i && !wr_hi_i) |=> $stable({hi_q, lo_q}));
  // R4
  gate_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_i && !lvl_i && mode_i != M_SPECIAL && !wr_lo_i && !wr_hi_i)
      |=> $stable({hi_q, lo_q}));
  // R7
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_RELOAD8 && inc && lo_q == ALL1 && !wr_lo_i) |=> lo_q == $past(hi_q));
  // R8
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!SPLIT_EN && mode_i == M_SPECIAL && !wr_lo_i && !wr_hi_i) |=> $stable({hi_q, lo_q}));
  // R9
  split_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SPLIT_EN && mode_i == M_SPECIAL && !aux_run_i && !wr_hi_i) |=> $stable(hi_q));
  // R10
  wr_lo_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> lo_q == $past(wdata_i));
  // R10
  wr_hi_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> hi_q == $past(wdata_i));
endmodule

// File: rtl/twin_timer_counter.sv
module twin_timer_counter
  import dtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic [NCH-1:0]    ext_i,
  output logic [NCH-1:0]    ovf_o
);
  logic [BYTE_W-1:0] mode_q;
  logic [NCH-1:0]    run_q, flag_q, flag_set, flag_clr;
  logic [NCH-1:0]    lvl, fall, ovf_main, ovf_aux;
  logic              tick, ctl_wr, split;
  chcfg_t            cfg   [NCH];
  logic [BYTE_W-1:0] lo_v  [NCH];
  logic [BYTE_W-1:0] hi_v  [NCH];

  assign ctl_wr = wr_en_i && (addr_i == A_CTL);

  tc_cycle_div #(.DIV(MC_DIV)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(A_LO0 + 2*i);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(A_LO0 + 2*i + 1);

    assign cfg[i] = chcfg_t'(mode_q[NIB_W*i +: NIB_W]);

    tc_edge_sense u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(tick),
      .ext_i (ext_i[i]),
      .lvl_o (lvl[i]),
      .fall_o(fall[i])
    );

    tc_channel #(.BW(BYTE_W), .PW(PRE_W), .SPLIT_EN(i == 0)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .fall_i   (fall[i]),
      .lvl_i    (lvl[i]),
      .run_i    (run_q[i]),
      .aux_run_i(run_q[NCH-1]),
      .gate_i   (cfg[i].gate),
      .ext_sel_i(cfg[i].ext_sel),
      .mode_i   (cfg[i].mode),
      .wr_lo_i  (wr_en_i && addr_i == A_LO),
      .wr_hi_i  (wr_en_i && addr_i == A_HI),
      .wdata_i  (wdata_i),
      .lo_o     (lo_v[i]),
      .hi_o     (hi_v[i]),
      .ovf_o    (ovf_main[i]),
      .ovf_aux_o(ovf_aux[i])
    );
  end

  // channel 0 in mode 11 takes over flag 1
  assign split       = (cfg[0].mode == M_SPECIAL);
  assign flag_set[0] = ovf_main[0];
  assign flag_set[1] = split ? ovf_aux[0] : (ovf_main[1] | ovf_aux[1]);
  assign flag_clr    = ctl_wr ? wdata_i[FLAG_LSB +: NCH] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_en_i && addr_i == A_MODE) mode_q <= wdata_i;
      if (ctl_wr) run_q <= wdata_i[RUN_LSB +: NCH];
      flag_q <= (flag_q | flag_set) & ~flag_clr;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_MODE) rdata_o = mode_q;
    if (addr_i == A_CTL) begin
      rdata_o[RUN_LSB +: NCH]  = run_q;
      rdata_o[FLAG_LSB +: NCH] = flag_q;
    end
    for (int k = 0; k < NCH; k++) begin
      if (addr_i == ADDR_W'(A_LO0 + 2*k))     rdata_o = lo_v[k];
      if (addr_i == ADDR_W'(A_LO0 + 2*k + 1)) rdata_o = hi_v[k];
    end
  end

  assign ovf_o = flag_q;

  for (genvar k = 0; k < NCH; k++) begin : g_flag_chk
    // R11
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[k] && !(ctl_wr && wdata_i[FLAG_LSB+k])) |=> flag_q[k]);
    // R11
    flag_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_q[k]) |-> $past(flag_set[k]));
  end
  // R9
  split_flag1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (split && !ovf_aux[0] && !flag_q[1]) |=> !flag_q[1]);
endmodule

// File: tb/twin_timer_counter_test.sv
module twin_timer_counter_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] ext = 2'b00;
  logic [1:0] ovf;
  logic       rd_req = 1'b0;
  int         n_chk = 0;
  int         n_bad = 0;

  typedef struct {
    logic [2:0] a;
    logic [7:0] e;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  twin_timer_counter uut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .ext_i  (ext),
    .ovf_o  (ovf)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling clock edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
    exp_t it;
    it.a = a; it.e = e; it.tag = tag;
    addr = a;
    sb_q.push_back(it);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // run-bit window of exactly 12*n clocks
  task automatic run_mc(input logic [1:0] bits, input int n);
    wr(3'd1, {6'b0, bits});
    idle(12*n - 1);
    wr(3'd1, 8'h00);
  endtask

  // monitor: pops expectations as reads are presented
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (rd_req) begin
        exp_t it;
        it = sb_q.pop_front();
        check(it.tag, rdata, it.e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(2);

    // R3 reset state
    for (int a = 0; a < 6; a++) rd_chk(3'(a), 8'h00, "R3 reset reg");
    check("R3 reset ovf", {6'b0, ovf}, 8'h00);
    wr(3'd0, 8'h5A);
    rd_chk(3'd0, 8'h5A, "R3 mode readback");

    // R1 / R6 timer mode, 16-bit
    wr(3'd0, 8'h01); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    run_mc(2'b01, 10);
    rd_chk(3'd2, 8'h0A, "R1 ten cycles low");
    wr(3'd2, 8'h00);
    run_mc(2'b01, 300);
    rd_chk(3'd2, 8'h2C, "R6 300 cycles low");
    rd_chk(3'd3, 8'h01, "R6 300 cycles high");

    // R6 wrap and R11 sticky flag
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    run_mc(2'b01, 3);
    rd_chk(3'd2, 8'h01, "R6 wrap low");
    rd_chk(3'd3, 8'h00, "R6 wrap high");
    rd_chk(3'd1, 8'h10, "R11 flag0 sticky after stop");
    check("R11 ovf pin set", {6'b0, ovf}, 8'h01);
    wr(3'd1, 8'h00);
    rd_chk(3'd1, 8'h10, "R11 zero write keeps flag");
    wr(3'd1, 8'h10);
    rd_chk(3'd1, 8'h00, "R11 one write clears flag");
    check("R11 ovf pin clear", {6'b0, ovf}, 8'h00);

    // R5 13-bit mode
    wr(3'd0, 8'h00); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    run_mc(2'b01, 3);
    rd_chk(3'd2, 8'hE1, "R5 prescale low");
    rd_chk(3'd3, 8'h00, "R5 high wrap");
    rd_chk(3'd1, 8'h10, "R5 flag0");
    wr(3'd1, 8'h30);

    // R7 auto-reload
    wr(3'd0, 8'h02); wr(3'd3, 8'h80); wr(3'd2, 8'hFE);
    run_mc(2'b01, 5);
    rd_chk(3'd2, 8'h83, "R7 reloaded low");
    rd_chk(3'd3, 8'h80, "R7 high kept");
    rd_chk(3'd1, 8'h10, "R7 flag0");
    wr(3'd1, 8'h30);

    // R2 counter mode on channel 1, 16-bit
    wr(3'd0, 8'h50); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    wr(3'd1, 8'h02);
    idle(30);
    for (int i = 0; i < 5; i++) begin
      ext[1] = 1'b1; idle(36);
      ext[1] = 1'b0; idle(36);
    end
    ext[1] = 1'b1; idle(36);
    wr(3'd1, 8'h00);
    rd_chk(3'd4, 8'h05, "R2 falling edges counted");
    rd_chk(3'd5, 8'h00, "R2 high untouched");
    ext[1] = 1'b0;

    // R4 gate on channel 0
    wr(3'd0, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    ext[0] = 1'b0; idle(6);
    run_mc(2'b01, 10);
    rd_chk(3'd2, 8'h00, "R4 gated low input blocks");
    ext[0] = 1'b1; idle(6);
    run_mc(2'b01, 10);
    rd_chk(3'd2, 8'h0A, "R4 gated high input counts");
    ext[0] = 1'b0;

    // R8 channel 1 frozen in mode 11
    wr(3'd0, 8'h30); wr(3'd4, 8'h12); wr(3'd5, 8'h34);
    run_mc(2'b10, 5);
    rd_chk(3'd4, 8'h12, "R8 frozen low");
    rd_chk(3'd5, 8'h34, "R8 frozen high");

    // R9 split channel 0
    wr(3'd1, 8'h30);
    wr(3'd0, 8'h03); wr(3'd2, 8'h00); wr(3'd3, 8'hFE);
    run_mc(2'b01, 4);
    rd_chk(3'd2, 8'h04, "R9 split low runs on run0");
    rd_chk(3'd3, 8'hFE, "R9 split high idle");
    run_mc(2'b10, 3);
    rd_chk(3'd3, 8'h01, "R9 split high runs on run1");
    rd_chk(3'd2, 8'h04, "R9 split low idle");
    rd_chk(3'd1, 8'h20, "R9 flag1 from split high");
    check("R9 ovf pins", {6'b0, ovf}, 8'h02);
    wr(3'd1, 8'h30);

    // R10 write beats increment while running
    wr(3'd0, 8'h01); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd1, 8'h01);
    idle(7);
    wr(3'd2, 8'h40);
    idle(12*3 - 1);
    wr(3'd1, 8'h00);
    rd_chk(3'd2, 8'h43, "R10 written low then counted");
    rd_chk(3'd3, 8'h00, "R10 high");

    idle(4);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule